// File: doc/BRIEF.md
# Memory-Mapped Burst Target for a Multiplexed Parallel Bus

This block is a 32-bit target on a shared bus where address and data travel on the same wires and every control line is active low. When the initiator pulls the frame line low, the block captures the address from the data pins and the command from the 4-bit command/enable group. It claims the cycle only for a memory read or memory write whose address falls inside its 16-word window. It then serves one or more data phases from a small internal register bank.

Each data phase finishes on the clock edge where the initiator-ready and target-ready lines are both low. The address steps forward by one word after every finished phase. Writes are qualified lane by lane through the byte enables. When a burst would run past the end of the window, the block disconnects it by raising a stop request at the same time as its last target-ready. After every claimed transaction the block drives its control lines high for one clock. It then releases them, which the port list models as an output enable.

Top module: `bus_target`

## Requirements
- R1: After reset, ctl_oe and ad_oe are 0 and devsel_n_o, trdy_n_o and stop_n_o are all 1.
- R2: A claimed cycle shows devsel_n_o low with trdy_n_o still high in the cycle after the address phase. trdy_n_o first goes low one cycle later.
- R3: The block claims a cycle only when cbe_n_i at the address phase is 4'b0110 (memory read) or 4'b0111 (memory write) and the address is inside the window. In any other case ctl_oe stays 0 for the whole transaction and the bank is not written.
- R4: A data phase completes only on an edge where irdy_n_i and trdy_n_o are both 0. A cycle where either is high is a wait state that keeps the current word.
- R5: On a write phase, cbe_n_i bit i low enables byte lane i, where bit 0 covers ad bits 7:0 and bit 3 covers bits 31:24. Lanes whose bit is high keep their old value.
- R6: On a read, ad_oe is 1 and ad_o carries the addressed word in every cycle that trdy_n_o is low. ad_oe is 0 in the turnaround cycle that follows the address phase.
- R7: The word address advances by one (byte address +4) after each completed phase of a burst.
- R8: When the initiator's frame_n_i is high at a completing edge, that phase is the last one. In the next cycle ctl_oe is 1 with devsel_n_o, trdy_n_o and stop_n_o all high, and in the cycle after that ctl_oe is 0.
- R9: A phase at the last word of the window shows stop_n_o low together with trdy_n_o low. If frame_n_i is still low after that phase completes, the block holds devsel_n_o and stop_n_o low with trdy_n_o high until frame_n_i is sampled high.
- R10: The window is WORDS 32-bit words starting at BASE. The word index is taken from address bits 5:2 for the default 16 words, and address bits 1:0 are ignored. An address one window-size above BASE is outside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ad_i | input | 32 | Address/data value seen on the bus |
| cbe_n_i | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frame_n_i | input | 1 | Transaction frame from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| ad_o | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Enable for ad_o |
| devsel_n_o | output | 1 | Claim of the cycle, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Request to end the transaction, active low |
| ctl_oe | output | 1 | Enable for devsel_n_o, trdy_n_o and stop_n_o |

## Verification
The bench targets the turnaround cycle. A target that raises target-ready or drives data there would finish a phase one clock early and return the wrong word in a read burst. Wait states inserted by the initiator show up in the cycle count. A design that completes on target-ready alone finishes too soon. A partial-lane write followed by a read-back exposes inverted or shifted byte enables. Unsupported commands and an address exactly one window above the base must leave the bank unchanged, which catches a decoder that drops upper address bits. Bursts that start near the top of the window must disconnect after the last word, hold the stop request until the frame line rises, and never wrap back to word zero.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_DATA,
    ST_STOPW,
    ST_TURN,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/bt_decode.sv
module bt_decode #(
  parameter int unsigned           ADDR_W = 32,
  parameter int unsigned           WORDS  = 16,
  parameter logic [ADDR_W-1:0]     BASE   = 32'h0000_4000,
  localparam int unsigned          IDX_W  = $clog2(WORDS),
  localparam int unsigned          OFS_W  = IDX_W + 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic unused_lsb;

  assign hit        = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
  assign idx        = addr[OFS_W-1:2];
  assign unused_lsb = ^addr[1:0];
endmodule

// File: rtl/bt_regbank.sv
module bt_regbank #(
  parameter int unsigned  DATA_W = 32,
  parameter int unsigned  WORDS  = 16,
  localparam int unsigned IDX_W  = $clog2(WORDS),
  localparam int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_arr [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(w));

    always_comb begin
      word_d = word_q;
      for (int b = 0; b < LANES; b++) begin
        if (wr_be[b]) word_d[b*8 +: 8] = wr_data[b*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (sel) word_q <= word_d;
    end

    assign rd_arr[w] = word_q;
  end

  assign rd_data = rd_arr[rd_idx];
endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
#(
  parameter int unsigned  WORDS = 16,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [3:0]       cbe_n,
  input  logic             hit,
  input  logic [IDX_W-1:0] start_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_en,
  output logic [3:0]       wr_be,
  output logic             ad_oe,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ctl_oe
);
  tgt_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rd_q, rd_d;
  logic             frame_prev_q;
  logic             start, cmd_ok, phase_done, at_last;

  assign start      = (state_q == ST_IDLE) && !frame_n && frame_prev_q;
  assign cmd_ok     = (cbe_n == CMD_MEM_RD) || (cbe_n == CMD_MEM_WR);
  assign phase_done = (state_q == ST_DATA) && !irdy_n;
  assign at_last    = (idx_q == IDX_W'(WORDS - 1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rd_d    = rd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (hit && cmd_ok) begin
            state_d = ST_CLAIM;
            idx_d   = start_idx;
            rd_d    = (cbe_n == CMD_MEM_RD);
          end else begin
            state_d = ST_SKIP;
          end
        end
      end
      ST_CLAIM: state_d = ST_DATA;
      ST_DATA: begin
        if (phase_done) begin
          if (frame_n)      state_d = ST_TURN;
          else if (at_last) state_d = ST_STOPW;
          else              idx_d   = idx_q + 1'b1;
        end
      end
      ST_STOPW: if (frame_n) state_d = ST_TURN;
      ST_TURN:  state_d = ST_IDLE;
      ST_SKIP:  if (frame_n && irdy_n) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      rd_q         <= 1'b0;
      frame_prev_q <= 1'b1;
    end else begin
      state_q      <= state_d;
      idx_q        <= idx_d;
      rd_q         <= rd_d;
      frame_prev_q <= frame_n;
    end
  end

  assign cur_idx  = idx_q;
  assign wr_en    = phase_done && !rd_q;
  assign wr_be    = ~cbe_n;
  assign ad_oe    = (state_q == ST_DATA) && rd_q;
  assign devsel_n = !((state_q == ST_CLAIM) || (state_q == ST_DATA) || (state_q == ST_STOPW));
  assign trdy_n   = !(state_q == ST_DATA);
  assign stop_n   = !((state_q == ST_STOPW) || ((state_q == ST_DATA) && at_last));
  assign ctl_oe   = (state_q == ST_CLAIM) || (state_q == ST_DATA) ||
                    (state_q == ST_STOPW) || (state_q == ST_TURN);
endmodule

// File: rtl/bus_target.sv
module bus_target #(
  parameter int unsigned       WORDS = 16,
  parameter logic [31:0]       BASE  = 32'h0000_4000,
  localparam int unsigned      IDX_W = $clog2(WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_n_i,
  input  logic        frame_n_i,
  input  logic        irdy_n_i,
  output logic [31:0] ad_o,
  output logic        ad_oe,
  output logic        devsel_n_o,
  output logic        trdy_n_o,
  output logic        stop_n_o,
  output logic        ctl_oe
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             hit;
  logic [IDX_W-1:0] start_idx, cur_idx;
  logic             wr_en;
  logic [3:0]       wr_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  bt_decode #(.ADDR_W(32), .WORDS(WORDS), .BASE(BASE)) u_decode (
    .addr (ad_i),
    .hit  (hit),
    .idx  (start_idx)
  );

  bt_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .frame_n   (frame_n_i),
    .irdy_n    (irdy_n_i),
    .cbe_n     (cbe_n_i),
    .hit       (hit),
    .start_idx (start_idx),
    .cur_idx   (cur_idx),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .ad_oe     (ad_oe),
    .devsel_n  (devsel_n_o),
    .trdy_n    (trdy_n_o),
    .stop_n    (stop_n_o),
    .ctl_oe    (ctl_oe)
  );

  bt_regbank #(.DATA_W(32), .WORDS(WORDS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_idx  (cur_idx),
    .wr_be   (wr_be),
    .wr_data (ad_i),
    .rd_idx  (cur_idx),
    .rd_data (ad_o)
  );
endmodule

// File: rtl/bt_checker.sv
module bt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n_i,
  input logic        irdy_n_i,
  input logic [31:0] ad_o,
  input logic        ad_oe,
  input logic        devsel_n_o,
  input logic        trdy_n_o,
  input logic        stop_n_o,
  input logic        ctl_oe
);
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> (!ad_oe && devsel_n_o && trdy_n_o)); // R1

  AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n_o |-> !devsel_n_o); // R2

  AST_CLAIM_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_o) |-> trdy_n_o); // R2

  AST_WAIT_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_o && irdy_n_i) |=> (!trdy_n_o && $stable(ad_o))); // R4

  AST_DATA_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n_o); // R6

  AST_RELEASE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && devsel_n_o && trdy_n_o && stop_n_o) |=> !ctl_oe); // R8

  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n_o && trdy_n_o && !frame_n_i) |=> (!stop_n_o && !devsel_n_o)); // R9
endmodule

bind bus_target bt_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n_i  (frame_n_i),
  .irdy_n_i   (irdy_n_i),
  .ad_o       (ad_o),
  .ad_oe      (ad_oe),
  .devsel_n_o (devsel_n_o),
  .trdy_n_o   (trdy_n_o),
  .stop_n_o   (stop_n_o),
  .ctl_oe     (ctl_oe)
);

// File: tb/test_bus_target.sv
module test_bus_target;
  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam logic [3:0]  RD   = 4'b0110;
  localparam logic [3:0]  WR   = 4'b0111;

  logic        clk;
  logic        rst_n;
  logic [31:0] ad_i;
  logic [3:0]  cbe_n;
  logic        frame_n, irdy_n;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n_o, trdy_n_o, stop_n_o, ctl_oe;

  int total, bad;

  logic [31:0] wdata [16];
  logic [3:0]  wbe   [16];
  logic [31:0] rdata [16];
  int x_done, x_iters;
  bit x_stop, x_claimed, x_sw_ok, x_turn_ok, x_idle_ok;
  logic x_dev0, x_trdy0, x_oe0, x_trdy1, x_oe1;

  bus_target #(.WORDS(16), .BASE(BASE)) i_bus_target (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .ad_o(ad_o), .ad_oe(ad_oe),
    .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o), .stop_n_o(stop_n_o),
    .ctl_oe(ctl_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input int n, input int waits);
    int i;
    int w;
    bit wr;
    wr = (cmd == WR);
    x_done = 0; x_iters = 0; x_stop = 0; x_claimed = 0;
    x_sw_ok = 0; x_turn_ok = 0; x_idle_ok = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_i = addr; cbe_n = cmd;
    @(negedge clk);
    i = 0; w = waits;
    for (int k = 0; k < 40; k++) begin
      ad_i  = wr ? wdata[i] : 32'h0;
      cbe_n = wr ? wbe[i] : 4'b0000;
      if (w > 0) begin irdy_n = 1'b1; frame_n = 1'b0; w--; end
      else begin irdy_n = 1'b0; frame_n = (i == n - 1); end
      if (k == 0) begin x_dev0 = devsel_n_o; x_trdy0 = trdy_n_o; x_oe0 = ad_oe; end
      if (k == 1) begin x_trdy1 = trdy_n_o; x_oe1 = ad_oe; end
      if (ctl_oe) x_claimed = 1;
      x_iters++;
      if (!irdy_n && !trdy_n_o && ctl_oe) begin
        rdata[i] = ad_o;
        if (!stop_n_o) x_stop = 1;
        x_done++;
        i++;
      end
      @(negedge clk);
      if (i == n || x_stop) break;
    end
    if (i != n && x_stop && !frame_n) begin
      x_sw_ok = ctl_oe && !devsel_n_o && trdy_n_o && !stop_n_o;
      frame_n = 1'b1; irdy_n = 1'b1;
      @(negedge clk);
    end else if (x_done == 0) begin
      frame_n = 1'b1; irdy_n = 1'b1;
      @(negedge clk);
    end
    x_turn_ok = ctl_oe && devsel_n_o && trdy_n_o && stop_n_o;
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    x_idle_ok = !ctl_oe;
  endtask

  task automatic t_reset;
    chk(!ctl_oe && !ad_oe, "R1 enables after reset", {30'h0, ctl_oe, ad_oe}, 32'h0);
    chk(devsel_n_o && trdy_n_o && stop_n_o, "R1 controls after reset",
        {29'h0, devsel_n_o, trdy_n_o, stop_n_o}, 32'h7);
  endtask

  task automatic t_write_burst;
    for (int k = 0; k < 4; k++) begin wdata[k] = 32'h1111_0000 + k; wbe[k] = 4'b0000; end
    xfer(WR, BASE, 4, 0);
    chk(x_done == 4, "R7 write burst phases", x_done, 4);
    chk(x_dev0 == 1'b0 && x_trdy0 == 1'b1, "R2 claim cycle", {30'h0, x_dev0, x_trdy0}, 32'h1);
    chk(x_trdy1 == 1'b0, "R2 trdy one cycle later", x_trdy1, 0);
    chk(x_turn_ok, "R8 driven high one clock", x_turn_ok, 1);
    chk(x_idle_ok, "R8 released after turn", x_idle_ok, 1);
  endtask

  task automatic t_read_burst;
    xfer(RD, BASE, 4, 0);
    chk(x_oe0 == 1'b0, "R6 no drive in turnaround", x_oe0, 0);
    chk(x_oe1 == 1'b1, "R6 drive with trdy", x_oe1, 1);
    for (int k = 0; k < 4; k++)
      chk(rdata[k] == 32'h1111_0000 + k, "R7 read burst data", rdata[k], 32'h1111_0000 + k);
  endtask

  task automatic t_byte_enables;
    wdata[0] = 32'hAABB_CCDD; wbe[0] = 4'b0000;
    xfer(WR, BASE + 32'd20, 1, 0);
    wdata[0] = 32'h1122_3344; wbe[0] = 4'b1010;
    xfer(WR, BASE + 32'd20, 1, 0);
    xfer(RD, BASE + 32'd20, 1, 0);
    chk(rdata[0] == 32'hAA22_CC44, "R5 lane merge", rdata[0], 32'hAA22_CC44);
  endtask

  task automatic t_waits;
    xfer(RD, BASE + 32'd20, 1, 3);
    chk(x_iters == 4, "R4 irdy wait states", x_iters, 4);
    chk(rdata[0] == 32'hAA22_CC44, "R4 data after waits", rdata[0], 32'hAA22_CC44);
    xfer(RD, BASE + 32'd4, 1, 0);
    chk(x_iters == 2, "R4 no completion while trdy high", x_iters, 2);
  endtask

  task automatic t_ignored;
    wdata[0] = 32'hDEAD_BEEF; wbe[0] = 4'b0000;
    xfer(4'b0011, BASE + 32'd4, 1, 0);
    chk(!x_claimed, "R3 other command ignored", x_claimed, 0);
    xfer(WR, BASE + 32'd64, 1, 0);
    chk(!x_claimed, "R10 outside window ignored", x_claimed, 0);
    xfer(RD, BASE, 2, 0);
    chk(rdata[0] == 32'h1111_0000, "R10 word 0 unchanged", rdata[0], 32'h1111_0000);
    chk(rdata[1] == 32'h1111_0001, "R3 word 1 unchanged", rdata[1], 32'h1111_0001);
  endtask

  task automatic t_low_bits;
    xfer(RD, BASE + 32'd14, 1, 0);
    chk(rdata[0] == 32'h1111_0003, "R10 low address bits", rdata[0], 32'h1111_0003);
  endtask

  task automatic t_disconnect;
    for (int k = 0; k < 4; k++) begin wdata[k] = 32'h5A5A_0000 + k; wbe[k] = 4'b0000; end
    xfer(WR, BASE + 32'd56, 4, 0);
    chk(x_done == 2, "R9 phases before disconnect", x_done, 2);
    chk(x_stop, "R9 stop with final trdy", x_stop, 1);
    chk(x_sw_ok, "R9 stop held until frame high", x_sw_ok, 1);
    chk(x_turn_ok, "R8 turn after disconnect", x_turn_ok, 1);
    xfer(RD, BASE + 32'd60, 3, 0);
    chk(x_done == 1, "R9 read at last word", x_done, 1);
    chk(rdata[0] == 32'h5A5A_0001, "R9 last word data", rdata[0], 32'h5A5A_0001);
    xfer(RD, BASE, 1, 0);
    chk(rdata[0] == 32'h1111_0000, "R9 no wrap to word 0", rdata[0], 32'h1111_0000);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; ad_i = '0; cbe_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_byte_enables();
    t_waits();
    t_ignored();
    t_low_bits();
    t_disconnect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule